// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block keeps the tag, valid and replacement-order state of one write-through, set-associative cache level, with no data storage behind it. Each access carries a read/write flag and a 48-bit byte address. The block decides hit or miss, installs missing blocks, and counts the memory traffic such a cache would cause. It is meant for fast hardware evaluation of cache configurations and for driving a trace through a modelled cache at one access per clock.

The total size, the block size and the number of ways are compile-time parameters, and each must be a power of two. They set how the address splits into offset, set index and tag. A run-time input selects the victim rule. Under first-in-first-out, the oldest fill is evicted and hits leave the order alone. Under least-recently-used, every access refreshes the recency of the line it touches. Both rules share one per-set age rank, so the rule can change between accesses. Writes always go to memory. A write that misses first fetches the block.

Top module: `cache_tag_ctrl`

## Requirements
- R1: After reset every line is invalid, all four counters read zero and `req_ready` is high, so the first access to any address is a miss.
- R2: The address splits into a block offset in the low log2(BLOCK_BYTES) bits, a set index in the next log2(SETS) bits, and a tag in the rest of the 48 bits. Addresses within one block share a line. Addresses that differ only in bit 47 fall in the same set but are different blocks.
- R3: With `repl_lru` = 0 (first-in-first-out), a miss in a full set evicts the way filled earliest, and hits never change that order.
- R4: With `repl_lru` = 1 (least-recently-used), a miss in a full set evicts the way whose last hit or fill is oldest.
- R5: A miss fills an invalid way if the set has one, so a set holds WAYS distinct blocks before anything is evicted.
- R6: A read hit adds one to the hit counter and changes neither memory counter.
- R7: A read miss adds one to the miss counter and one to the memory-read counter, and installs the block.
- R8: A write hit adds one to the hit counter and one to the memory-write counter, and leaves the memory-read counter unchanged.
- R9: A write miss adds one to the miss counter, one to the memory-read counter and one to the memory-write counter, and installs the block, so a following read of it hits.
- R10: An access is accepted on a clock edge where `req_valid` and `req_ready` are both high. `rsp_valid` and `rsp_hit` describe it in the next cycle, together with the updated counters. `rsp_valid` is low in any cycle that follows no acceptance.
- R11: The policy input is sampled per access and can change between accesses, while the stored order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| repl_lru | input | 1 | Victim rule: 1 least-recently-used, 0 first-in-first-out |
| req_valid | input | 1 | Access offered |
| req_ready | output | 1 | Block can take an access |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 48 | Byte address, zero-extended |
| rsp_valid | output | 1 | Result of the access accepted one cycle earlier |
| rsp_hit | output | 1 | That access hit |
| cnt_mem_rd | output | CNT_W | Memory block reads so far |
| cnt_mem_wr | output | CNT_W | Memory writes so far |
| cnt_hit | output | CNT_W | Cache hits so far |
| cnt_miss | output | CNT_W | Cache misses so far |

## Verification
The hardest case to reach is a full set whose order differs between the two rules. This needs hits on older lines between fills, and then a miss that exposes the chosen victim, possibly after the policy input has changed part way through. Directed sequences fill one set, hit its oldest line and then force an eviction under each rule, with a later probe showing which block left. A long random run then works on a small pool of blocks, some differing only in bit 47. It crowds a few sets, toggles the policy every few hundred accesses, and compares every response with a queue-per-set model.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  typedef enum logic {
    POL_FIFO = 1'b0,
    POL_LRU  = 1'b1
  } repl_pol_e;
endpackage

// File: rtl/ctc_way_match.sv
module ctc_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 41,
  localparam int WW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            valid_row,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_row,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WW-1:0]              hit_way,
  output logic                       has_free,
  output logic [WW-1:0]              free_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_row[w] && (tag_row[w] == tag);
  end

  always_comb begin
    hit      = |match;
    has_free = ~&valid_row;
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w])      hit_way  = WW'(w);
      if (!valid_row[w]) free_way = WW'(w);
    end
  end
endmodule

// File: rtl/ctc_repl_rank.sv
module ctc_repl_rank
  import ctc_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WW  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  repl_pol_e               pol,
  input  logic [WAYS-1:0][WW-1:0] rank_row,
  input  logic                    hit,
  input  logic [WW-1:0]           hit_way,
  input  logic                    has_free,
  input  logic [WW-1:0]           free_way,
  output logic [WW-1:0]           victim,
  output logic                    rank_we,
  output logic [WAYS-1:0][WW-1:0] rank_next,
  output logic [WAYS-1:0]         rank_seen
);
  logic [WW-1:0] oldest;
  logic [WW-1:0] touch;

  function automatic logic [WW-1:0] f_age(input logic [WW-1:0] cur,
                                          input logic [WW-1:0] ref_rank,
                                          input logic          is_touch);
    if (is_touch)             return '0;
    else if (cur < ref_rank)  return cur + 1'b1;
    else                      return cur;
  endfunction

  always_comb begin
    oldest    = '0;
    rank_seen = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (rank_row[w] == WW'(WAYS - 1)) oldest = WW'(w);
      if (32'(rank_row[w]) < WAYS) rank_seen[rank_row[w]] = 1'b1;
    end
    victim  = has_free ? free_way : oldest;
    touch   = hit ? hit_way : victim;
    rank_we = !hit || (pol == POL_LRU);
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_age
    assign rank_next[w] = f_age(rank_row[w], rank_row[touch], touch == WW'(w));
  end
endmodule

// File: rtl/ctc_tag_store.sv
module ctc_tag_store #(
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  parameter int TAG_W = 41,
  localparam int WW   = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SW   = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SW-1:0]              set_idx,
  output logic [WAYS-1:0]            valid_row,
  output logic [WAYS-1:0][TAG_W-1:0] tag_row,
  output logic [WAYS-1:0][WW-1:0]    rank_row,
  input  logic                       fill_en,
  input  logic [WW-1:0]              fill_way,
  input  logic [TAG_W-1:0]           fill_tag,
  input  logic                       rank_en,
  input  logic [WAYS-1:0][WW-1:0]    rank_in
);
  logic [WAYS-1:0]         valid_q [SETS];
  logic [TAG_W-1:0]        tag_q   [SETS][WAYS];
  logic [WAYS-1:0][WW-1:0] rank_q  [SETS];

  always_comb begin
    valid_row = valid_q[set_idx];
    rank_row  = rank_q[set_idx];
    for (int w = 0; w < WAYS; w++) tag_row[w] = tag_q[set_idx][w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w]  <= '0;
          rank_q[s][w] <= WW'(w);
        end
      end
    end else begin
      if (fill_en) begin
        valid_q[set_idx][fill_way] <= 1'b1;
        tag_q[set_idx][fill_way]   <= fill_tag;
      end
      if (rank_en) rank_q[set_idx] <= rank_in;
    end
  end
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import ctc_pkg::*;
#(
  parameter int CACHE_BYTES = 128,
  parameter int BLOCK_BYTES = 4,
  parameter int WAYS        = 4,
  parameter int CNT_W       = 32,
  localparam int ADDR_W     = 48,
  localparam int SETS       = CACHE_BYTES / (BLOCK_BYTES * WAYS),
  localparam int OFF_W      = $clog2(BLOCK_BYTES),
  localparam int IDX_BITS   = $clog2(SETS),
  localparam int SW         = (SETS > 1) ? IDX_BITS : 1,
  localparam int TAG_W      = ADDR_W - OFF_W - IDX_BITS,
  localparam int WW         = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              repl_lru,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [CNT_W-1:0]  cnt_mem_rd,
  output logic [CNT_W-1:0]  cnt_mem_wr,
  output logic [CNT_W-1:0]  cnt_hit,
  output logic [CNT_W-1:0]  cnt_miss
);
  function automatic logic [SW-1:0] f_set(input logic [ADDR_W-1:0] a);
    return SW'((a >> OFF_W) % SETS);
  endfunction

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return TAG_W'(a >> (OFF_W + IDX_BITS));
  endfunction

  repl_pol_e                 pol;
  logic                      acc;
  logic                      rdy_q;
  logic [SW-1:0]             set_idx;
  logic [TAG_W-1:0]          tag;
  logic [WAYS-1:0]           valid_row;
  logic [WAYS-1:0][TAG_W-1:0] tag_row;
  logic [WAYS-1:0][WW-1:0]   rank_row;
  logic [WAYS-1:0][WW-1:0]   rank_next;
  logic [WAYS-1:0]           rank_seen;
  logic                      hit;
  logic [WW-1:0]             hit_way;
  logic                      has_free;
  logic [WW-1:0]             free_way;
  logic [WW-1:0]             victim;
  logic                      rank_we;
  logic                      fill_ev;
  logic                      rank_ev;
  logic                      unused_offset;

  assign pol           = repl_lru ? POL_LRU : POL_FIFO;
  assign req_ready     = rdy_q;
  assign acc           = req_valid && rdy_q;
  assign set_idx       = f_set(req_addr);
  assign tag           = f_tag(req_addr);
  assign fill_ev       = acc && !hit;
  assign rank_ev       = acc && rank_we;
  assign unused_offset = ^req_addr[OFF_W-1:0];

  ctc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_idx  (set_idx),
    .valid_row(valid_row),
    .tag_row  (tag_row),
    .rank_row (rank_row),
    .fill_en  (fill_ev),
    .fill_way (victim),
    .fill_tag (tag),
    .rank_en  (rank_ev),
    .rank_in  (rank_next)
  );

  ctc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .valid_row(valid_row),
    .tag_row  (tag_row),
    .tag      (tag),
    .hit      (hit),
    .hit_way  (hit_way),
    .has_free (has_free),
    .free_way (free_way)
  );

  ctc_repl_rank #(.WAYS(WAYS)) u_repl (
    .pol      (pol),
    .rank_row (rank_row),
    .hit      (hit),
    .hit_way  (hit_way),
    .has_free (has_free),
    .free_way (free_way),
    .victim   (victim),
    .rank_we  (rank_we),
    .rank_next(rank_next),
    .rank_seen(rank_seen)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q      <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      cnt_mem_rd <= '0;
      cnt_mem_wr <= '0;
      cnt_hit    <= '0;
      cnt_miss   <= '0;
    end else begin
      rdy_q     <= 1'b1;
      rsp_valid <= acc;
      if (acc) begin
        rsp_hit <= hit;
        if (hit) cnt_hit  <= cnt_hit + 1'b1;
        else     cnt_miss <= cnt_miss + 1'b1;
        if (!hit)      cnt_mem_rd <= cnt_mem_rd + 1'b1;
        if (req_write) cnt_mem_wr <= cnt_mem_wr + 1'b1;
      end
    end
  end

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid) else $error("response missing"); // R10
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid) else $error("spurious response"); // R10
  AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write) |=> (cnt_mem_wr == $past(cnt_mem_wr) + 1'b1)) else $error("write not counted"); // R8
  AST_RD_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && hit) |=> ($stable(cnt_mem_rd) && $stable(cnt_mem_wr))) else $error("read hit caused traffic"); // R6
  AST_MISS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !hit) |=> (cnt_mem_rd == $past(cnt_mem_rd) + 1'b1)) else $error("miss without fetch"); // R9
  AST_FIFO_HIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hit && pol == POL_FIFO) |-> !rank_ev) else $error("fifo hit moved order"); // R3
  AST_RANK_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> (&rank_seen)) else $error("age ranks not a permutation"); // R4
endmodule

// File: tb/cache_tag_ctrl_tb.sv
module cache_tag_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CB    = 128;
  localparam int BB    = 4;
  localparam int NW    = 4;
  localparam int NSETS = CB / (BB * NW);
  localparam longint unsigned STRIDE = NSETS * BB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        repl_lru = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [47:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] cnt_mem_rd, cnt_mem_wr, cnt_hit, cnt_miss;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  longint unsigned mq [NSETS][$];
  longint unsigned m_rd, m_wr, m_hit, m_miss;
  bit last_hit;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cache_tag_ctrl #(.CACHE_BYTES(CB), .BLOCK_BYTES(BB), .WAYS(NW), .CNT_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .repl_lru(repl_lru), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .cnt_mem_rd(cnt_mem_rd),
    .cnt_mem_wr(cnt_mem_wr), .cnt_hit(cnt_hit), .cnt_miss(cnt_miss)
  );

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < NSETS; s++) mq[s].delete();
    m_rd = 0; m_wr = 0; m_hit = 0; m_miss = 0;
  endtask

  task automatic model_step(input bit w, input longint unsigned a, input bit lru);
    longint unsigned blk;
    int s;
    int pos;
    blk = a / BB;
    s = int'(blk % NSETS);
    pos = -1;
    for (int i = 0; i < mq[s].size(); i++) if (mq[s][i] == blk) pos = i;
    last_hit = (pos >= 0);
    if (last_hit) begin
      m_hit++;
      if (lru) begin
        mq[s].delete(pos);
        mq[s].push_back(blk);
      end
    end else begin
      m_miss++;
      m_rd++;
      if (mq[s].size() == NW) void'(mq[s].pop_front());
      mq[s].push_back(blk);
    end
    if (w) m_wr++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    check("R1 ready after reset", req_ready, 1);
    check("R1 mem_rd zero", cnt_mem_rd, 0);
    check("R1 mem_wr zero", cnt_mem_wr, 0);
    check("R1 hit zero", cnt_hit, 0);
    check("R1 miss zero", cnt_miss, 0);
  endtask

  task automatic access(input bit w, input longint unsigned a);
    while (!req_ready) @(negedge clk);
    req_write = w;
    req_addr  = 48'(a);
    req_valid = 1'b1;
    model_step(w, a, repl_lru);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 rsp_valid after accept", rsp_valid, 1);
    check("R3 R4 R5 hit vs model", rsp_hit, last_hit);
    check("R7 R9 mem_rd", cnt_mem_rd, m_rd);
    check("R8 R9 mem_wr", cnt_mem_wr, m_wr);
    check("R6 R8 hit count", cnt_hit, m_hit);
    check("R7 miss count", cnt_miss, m_miss);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    longint unsigned a0, b0, c0, d0, e0, hi;
    longint unsigned rd0, wr0;
    a0 = 0; b0 = STRIDE; c0 = 2 * STRIDE; d0 = 3 * STRIDE; e0 = 4 * STRIDE;
    hi = 64'h8000_0000_0000;

    // R1, R3, R5: first-in-first-out, hit on A does not save it
    repl_lru = 1'b0;
    do_reset();
    access(0, a0);
    check("R1 first access misses", rsp_hit, 0);
    access(0, b0); access(0, c0); access(0, d0);
    access(0, a0);
    check("R5 four fills kept, A hits", rsp_hit, 1);
    access(0, e0);
    access(0, b0);
    check("R3 fifo: B still present", rsp_hit, 1);
    access(0, a0);
    check("R3 fifo: A was evicted", rsp_hit, 0);

    // R4: least-recently-used, hit on A protects it, B leaves
    repl_lru = 1'b1;
    do_reset();
    access(0, a0); access(0, b0); access(0, c0); access(0, d0);
    access(0, a0);
    access(0, e0);
    access(0, a0);
    check("R4 lru: A kept", rsp_hit, 1);
    access(0, b0);
    check("R4 lru: B was evicted", rsp_hit, 0);

    // R6 .. R9: traffic rules
    do_reset();
    access(1, 8);
    check("R9 write miss result", rsp_hit, 0);
    check("R9 write miss mem_rd", cnt_mem_rd, 1);
    check("R9 write miss mem_wr", cnt_mem_wr, 1);
    access(0, 8);
    check("R9 block installed by write miss", rsp_hit, 1);
    rd0 = cnt_mem_rd; wr0 = cnt_mem_wr;
    access(1, 9);
    check("R8 write hit", rsp_hit, 1);
    check("R8 write hit mem_rd unchanged", cnt_mem_rd, rd0);
    check("R8 write hit mem_wr +1", cnt_mem_wr, wr0 + 1);
    access(0, 11);
    check("R6 read hit mem_rd unchanged", cnt_mem_rd, rd0);
    check("R6 read hit mem_wr unchanged", cnt_mem_wr, wr0 + 1);

    // R2: offset inside block, bit 47 as tag
    access(0, 40);
    access(0, 40 | hi);
    check("R2 bit 47 is a different block", rsp_hit, 0);
    access(0, 43);
    check("R2 same block other offset", rsp_hit, 1);
    access(0, 43 | hi);
    check("R2 high block also held", rsp_hit, 1);

    // R10: idle cycle carries no response
    @(negedge clk);
    check("R10 rsp_valid low when idle", rsp_valid, 0);

    // R11: random traffic with policy toggling
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      longint unsigned blk;
      if (i % 250 == 0) repl_lru = ~repl_lru;
      blk = longint'($urandom_range(0, 39));
      access(bit'($urandom_range(0, 1)),
             blk * BB + longint'($urandom_range(0, BB - 1)) +
             (($urandom_range(0, 3) == 0) ? hi : 0));
    end
    check("R11 final hit total", cnt_hit, m_hit);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule